// File: doc/BRIEF.md
# Conditional Jump Evaluation Unit

This unit resolves the relative jump class of a 16-bit instruction set. Each cycle that a valid instruction word is offered, the unit works out whether the word belongs to the jump class. If it does, the unit checks the word's condition against the current carry, zero, negative and overflow flags. It also forms the branch destination from the program counter the caller supplies, which already points at the instruction after the jump.

The destination is formed from a signed word offset held in the low ten bits of the instruction. The offset is sign-extended, doubled to a byte distance and added to the supplied program counter, wrapping at 16 bits. The unit only reads the flags and never writes them back. Fetch, the register file and pipeline steering belong to the surrounding core. All results are registered and appear one clock after the instruction is presented.

Top module: `jmp_eval_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid instruction has been processed, resValid, isJump, takeJump and jumpTarget are all 0.
- R2: An instruction sampled with instValid high at a rising edge produces resValid high for exactly the following cycle. A cycle without a sampled instruction gives resValid, isJump, takeJump and jumpTarget all 0.
- R3: A word is in the jump class exactly when its bits 15:13 are 001, which means its leading hex digit is 2 or 3. isJump reports this class.
- R4: A word outside the jump class gives isJump=0, takeJump=0 and jumpTarget=0. takeJump is never 1 unless isJump is 1.
- R5: The condition field is bits 12:10. Code 000 is taken when Z=0, and code 001 is taken when Z=1.
- R6: Code 010 is taken when C=0, and code 011 is taken when C=1.
- R7: Code 100 is taken when N=1, whatever the values of C, Z and V.
- R8: Code 101 (signed greater-or-equal) is taken when N XOR V is 0. Code 110 (signed less) is taken when N XOR V is 1.
- R9: Code 111 is taken for every flag combination.
- R10: For a jump-class word, jumpTarget equals pcNext plus twice the sign-extended bits 9:0, modulo 2^16. This holds whether or not the jump is taken, and bit 0 of jumpTarget is always 0.
- R11: The offset extremes are handled correctly. 0x1FF moves the target forward by 1022 bytes and 0x200 moves it back by 1024 bytes, with wrap-around through address 0 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instValid | input | 1 | instWord, pcNext and the flags are valid this cycle |
| instWord | input | 16 | Instruction word to evaluate |
| pcNext | input | 16 | Address of the instruction following this one |
| flagC | input | 1 | Carry flag |
| flagZ | input | 1 | Zero flag |
| flagN | input | 1 | Negative flag |
| flagV | input | 1 | Overflow flag |
| resValid | output | 1 | Result of the previous cycle's instruction is present |
| isJump | output | 1 | Instruction was in the jump class |
| takeJump | output | 1 | Jump condition held |
| jumpTarget | output | 16 | Branch destination (0 when not a jump) |

## Verification
Each of the four results is due on the rising edge right after the one that sampled the instruction, because each passes through a single register. The driver applies a stimulus on a falling edge and, at that moment, queues the expected decode, decision and target. The monitor samples two nanoseconds after each rising edge. If anything is queued, it requires resValid in that cycle and compares all three results. If nothing is queued, it requires resValid and the other outputs to be quiet. A late, early or missing result therefore shows up as a mismatch in the very cycle it was due.

// File: rtl/jmp_eval_pkg.sv
package jmp_eval_pkg;

  localparam int COND_W   = 3;
  localparam int NUM_COND = 1 << COND_W;
  localparam int CLASS_W  = 3;
  localparam logic [CLASS_W-1:0] JUMP_CLASS = 3'b001;

  typedef enum logic [COND_W-1:0] {
    COND_NONZERO = 3'd0,
    COND_ZERO    = 3'd1,
    COND_NOCARRY = 3'd2,
    COND_CARRY   = 3'd3,
    COND_NEG     = 3'd4,
    COND_SGE     = 3'd5,
    COND_SLT     = 3'd6,
    COND_ALWAYS  = 3'd7
  } jmpCond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;

  // Strobes from control to the target datapath
  typedef struct packed {
    logic capture;  // load the computed target
    logic clear;    // force the target register to zero
  } dpStrobe_t;

  function automatic logic condHolds(input jmpCond_e cond, input flags_t f);
    logic res;
    case (cond)
      COND_NONZERO: res = ~f.z;
      COND_ZERO:    res = f.z;
      COND_NOCARRY: res = ~f.c;
      COND_CARRY:   res = f.c;
      COND_NEG:     res = f.n;
      COND_SGE:     res = ~(f.n ^ f.v);
      COND_SLT:     res = f.n ^ f.v;
      default:      res = 1'b1;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/jmp_eval_ctrl.sv
module jmp_eval_ctrl
  import jmp_eval_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  input  flags_t            flags,
  output logic              validQ,
  output logic              jumpQ,
  output logic              takeQ,
  output dpStrobe_t         strobe
);

  localparam int CLASS_MSB = WORD_W - 1;
  localparam int COND_MSB  = WORD_W - 1 - CLASS_W;

  logic [CLASS_W-1:0]  classField;
  logic [COND_W-1:0]   condField;
  logic [NUM_COND-1:0] condMet;
  logic                classHit;
  logic                condHit;

  assign classField = instWord[CLASS_MSB -: CLASS_W];
  assign condField  = instWord[COND_MSB -: COND_W];
  assign classHit   = (classField == JUMP_CLASS);

  // Evaluate every condition in parallel, select by the field
  for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
    localparam logic [COND_W-1:0] IDX = g;
    assign condMet[g] = condHolds(jmpCond_e'(IDX), flags);
  end

  assign condHit = condMet[condField];

  always_comb begin
    strobe.capture = instValid & classHit;
    strobe.clear   = ~(instValid & classHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      jumpQ  <= 1'b0;
      takeQ  <= 1'b0;
    end else begin
      validQ <= instValid;
      jumpQ  <= instValid & classHit;
      takeQ  <= instValid & classHit & condHit;
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> validQ); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !validQ |-> (!jumpQ && !takeQ)); // R2

  AST_TAKE_NEEDS_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    takeQ |-> jumpQ); // R4

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[CLASS_MSB -: CLASS_W] == 3'b001 &&
     instWord[COND_MSB -: COND_W] == 3'b111) |=> takeQ); // R9

  AST_ZERO_COND: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[CLASS_MSB -: CLASS_W] == 3'b001 &&
     instWord[COND_MSB -: COND_W] == 3'b001) |=> (takeQ == $past(flags.z))); // R5

endmodule

// File: rtl/jmp_eval_datapath.sv
module jmp_eval_datapath
  import jmp_eval_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OFS_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] instWord,
  input  logic [WORD_W-1:0] pcNext,
  output logic [WORD_W-1:0] tgtQ
);

  localparam int EXT_W = WORD_W - OFS_W - 1;

  logic [OFS_W-1:0]  wordOfs;
  logic [WORD_W-1:0] byteOfs;
  logic [WORD_W-1:0] tgtSum;

  assign wordOfs = instWord[OFS_W-1:0];
  // sign-extend and scale to bytes
  assign byteOfs = {{EXT_W{wordOfs[OFS_W-1]}}, wordOfs, 1'b0};
  assign tgtSum  = pcNext + byteOfs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtQ <= '0;
    end else if (strobe.capture) begin
      tgtQ <= tgtSum;
    end else if (strobe.clear) begin
      tgtQ <= '0;
    end
  end

  AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (tgtQ[0] == 1'b0)); // R10

  AST_TARGET_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> (tgtQ == '0)); // R4

endmodule

// File: rtl/jmp_eval_unit.sv
module jmp_eval_unit
  import jmp_eval_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OFS_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  input  logic [WORD_W-1:0] pcNext,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic              flagN,
  input  logic              flagV,
  output logic              resValid,
  output logic              isJump,
  output logic              takeJump,
  output logic [WORD_W-1:0] jumpTarget
);

  flags_t    flagsIn;
  dpStrobe_t strobe;

  assign flagsIn = '{c: flagC, z: flagZ, n: flagN, v: flagV};

  jmp_eval_ctrl #(
    .WORD_W (WORD_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instWord  (instWord),
    .flags     (flagsIn),
    .validQ    (resValid),
    .jumpQ     (isJump),
    .takeQ     (takeJump),
    .strobe    (strobe)
  );

  jmp_eval_datapath #(
    .WORD_W (WORD_W),
    .OFS_W  (OFS_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .instWord (instWord),
    .pcNext   (pcNext),
    .tgtQ     (jumpTarget)
  );

  AST_CLASS_DETECT: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> (isJump == ($past(instWord[WORD_W-1 -: 3]) == 3'b001))); // R3

endmodule

// File: tb/jmp_eval_unit_tb.sv
module jmp_eval_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [15:0] instWord = '0;
  logic [15:0] pcNext = '0;
  logic        flagC = 1'b0, flagZ = 1'b0, flagN = 1'b0, flagV = 1'b0;
  logic        resValid, isJump, takeJump;
  logic [15:0] jumpTarget;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic        expJump;
    logic        expTake;
    logic [15:0] expTgt;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];

  always #10 clk = ~clk;  // 50 MHz

  jmp_eval_unit u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .instWord   (instWord),
    .pcNext     (pcNext),
    .flagC      (flagC),
    .flagZ      (flagZ),
    .flagN      (flagN),
    .flagV      (flagV),
    .resValid   (resValid),
    .isJump     (isJump),
    .takeJump   (takeJump),
    .jumpTarget (jumpTarget)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model from the requirements
  function automatic logic refTake(input logic [2:0] cond, input logic c, z, n, v);
    case (cond)
      3'd0: return !z;        // R5
      3'd1: return z;         // R5
      3'd2: return !c;        // R6
      3'd3: return c;         // R6
      3'd4: return n;         // R7
      3'd5: return !(n ^ v);  // R8
      3'd6: return n ^ v;     // R8
      default: return 1'b1;   // R9
    endcase
  endfunction

  function automatic string condTag(input logic [2:0] cond);
    case (cond)
      3'd0, 3'd1: return "R5";
      3'd2, 3'd3: return "R6";
      3'd4:       return "R7";
      3'd5, 3'd6: return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic drive(input logic [15:0] w, input logic [15:0] pc,
                       input logic c, z, n, v, input string tagOverride);
    expItem_t it;
    logic signed [15:0] ofsBytes;
    @(negedge clk);
    instValid = 1'b1;
    instWord  = w;
    pcNext    = pc;
    flagC = c; flagZ = z; flagN = n; flagV = v;
    it.expJump = (w[15:13] == 3'b001);                       // R3
    ofsBytes   = 16'($signed(w[9:0])) * 16'sd2;              // R10
    it.expTake = it.expJump && refTake(w[12:10], c, z, n, v);
    it.expTgt  = it.expJump ? 16'(pc + ofsBytes) : 16'h0000; // R4 / R10
    it.tag     = (tagOverride != "") ? tagOverride :
                 (it.expJump ? condTag(w[12:10]) : "R4");
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      instValid = 1'b0;
      instWord  = 16'h2ABC;  // jump-looking word, must be ignored
    end
  endtask

  // Monitor: results are due one rising edge after the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN) begin
        if (sbq.size() != 0) begin
          expItem_t it;
          it = sbq.pop_front();
          check(resValid === 1'b1, "R2", "resValid", 16'(resValid), 16'h1);
          check(isJump === it.expJump, (it.tag == "R4") ? "R4" : "R3", "isJump",
                16'(isJump), 16'(it.expJump));
          check(takeJump === it.expTake, it.tag, "takeJump",
                16'(takeJump), 16'(it.expTake));
          check(jumpTarget === it.expTgt, (it.tag == "R11") ? "R11" :
                (it.expJump ? "R10" : "R4"), "jumpTarget", jumpTarget, it.expTgt);
        end else begin
          check(resValid === 1'b0 && isJump === 1'b0 && takeJump === 1'b0 &&
                jumpTarget === 16'h0, "R2", "idle outputs",
                {resValid, isJump, takeJump, jumpTarget[12:0]}, 16'h0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(20 * 100000);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    instValid = 1'b1;
    instWord  = 16'h3C00;
    check(resValid === 1'b0 && isJump === 1'b0 && takeJump === 1'b0 &&
          jumpTarget === 16'h0, "R1", "reset outputs",
          {resValid, isJump, takeJump, jumpTarget[12:0]}, 16'h0);
    @(negedge clk);
    instValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(resValid === 1'b0 && isJump === 1'b0 && takeJump === 1'b0 &&
          jumpTarget === 16'h0, "R1", "post-reset outputs",
          {resValid, isJump, takeJump, jumpTarget[12:0]}, 16'h0);

    // All eight conditions against all sixteen flag combinations
    for (int cnd = 0; cnd < 8; cnd++) begin
      for (int f = 0; f < 16; f++) begin
        drive({3'b001, 3'(cnd), 10'(f * 7)}, 16'(16'h4000 + f * 2),
              f[3], f[2], f[1], f[0], "");
      end
      idle(1);
    end

    // R4: words outside the jump class
    drive(16'h4035, 16'h1000, 1, 1, 1, 1, "R4");
    drive(16'h1300, 16'h1000, 1, 1, 1, 1, "R4");
    drive(16'h0000, 16'h1000, 1, 1, 1, 1, "R4");
    drive(16'h5FFF, 16'h1000, 1, 1, 1, 1, "R4");
    drive(16'hC3FF, 16'h1000, 1, 1, 1, 1, "R4");
    drive(16'h1FFF, 16'h1000, 1, 1, 1, 1, "R4");
    idle(2);

    // R11: offset extremes and wrap-around
    drive(16'h3DFF, 16'h0100, 0, 0, 0, 0, "R11");  // +511 words
    drive(16'h3E00, 16'h0800, 0, 0, 0, 0, "R11");  // -512 words
    drive(16'h3DFF, 16'hFF00, 0, 0, 0, 0, "R11");  // wrap up through 0
    drive(16'h3E00, 16'h0004, 0, 0, 0, 0, "R11");  // wrap down through 0
    drive(16'h3C00, 16'h1234, 0, 0, 0, 0, "R11");  // zero offset
    // R10: target formed even when not taken
    drive(16'h2003, 16'h2000, 0, 1, 0, 0, "R10");  // jnz with Z=1, not taken
    drive(16'h25FF, 16'h3000, 0, 1, 0, 0, "R10");
    idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule